// File: doc/BRIEF.md
# Cascadable parallel-to-serial shift register

This block turns a parallel word into a serial bit stream. On a rising clock edge it either captures a whole word from its parallel input, or moves every stored bit one place toward the output while taking a fresh bit from a serial input. Only the last stage of the register is visible, as the serial output.

An active-low clock enable lets the register hold its contents across any number of edges. An active-low clear empties the register at once, without waiting for a clock edge, and overrides every other input.

The width is a parameter with a default of 8. Wider converters are formed by tying the serial output of one instance to the serial input of the next, with all instances sharing clock, enable, load select and clear. A chain of N instances then behaves exactly like one register N times as wide.

Top module: `piso_shifter`

## Requirements
- R1: The serial output is always the top stored position (index WIDTH-1). After clear it reads 0.
- R2: While clearN is low, every stored position is 0 with no clock edge needed, and load, shift and enable have no effect. The output is already 0 before the next rising edge.
- R3: At a rising edge with clkEnN low and loadN low, parIn[i] is stored into position i for every i. serOut then shows parIn[WIDTH-1] after that edge.
- R4: At a rising edge with clkEnN low and loadN high, position 0 takes serIn and each position i>0 takes the old value of position i-1.
- R5: At a rising edge with clkEnN high, the stored word does not change, whatever loadN, parIn and serIn are.
- R6: A loaded word leaves the output most significant bit first. Bit i appears after WIDTH-1-i shift edges.
- R7: With serOut of a first instance wired to serIn of a second, the pair serialises a 2*WIDTH-bit word. The second instance's output gives its own loaded bits first, then the first instance's bits, MSB first.
- R8: A load that follows a partial shift replaces all positions, leaving none of the partly shifted bits behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Asynchronous clear, active low, highest priority |
| clkEnN | input | 1 | Clock enable, active low; high holds the register |
| loadN | input | 1 | Low selects parallel load, high selects shift |
| serIn | input | 1 | Bit entering position 0 on a shift |
| parIn | input | WIDTH | Parallel word, bit i to position i |
| serOut | output | 1 | Top position of the register |

## Verification
A load, shift or hold decided at a rising edge shows on serOut in the same edge, since there is one register stage. The driver sets inputs at the falling edge and queues the predicted output. The monitor pops that prediction shortly after the following rising edge, so each comparison falls exactly one edge after its stimulus. A clear is the exception: it takes effect with no edge at all. It is checked one time unit after clearN falls, in the middle of the clock phase, and again after an edge during which a load was requested.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic doLoad;
    logic doShift;
  } stepStrobes_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic         clkEnN,
  input  logic         loadN,
  output stepStrobes_t strobes
);
  // Enable gates both actions; load select then picks load over shift.
  always_comb begin
    strobes = '0;
    if (!clkEnN) begin
      if (!loadN) strobes.doLoad  = 1'b1;
      else        strobes.doShift = 1'b1;
    end
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  stepStrobes_t     strobes,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut
);
  localparam int TOP = WIDTH - 1;

  logic [TOP:0] stateQ;

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN)              stateQ <= '0;
    else if (strobes.doLoad)  stateQ <= parIn;
    else if (strobes.doShift) stateQ <= {stateQ[TOP-1:0], serIn};
  end

  assign serOut = stateQ[TOP];

  // R3: a load captures the whole parallel word
  a_r3_load_capture: assert property (@(posedge clk) disable iff (!clearN)
    strobes.doLoad |=> stateQ == $past(parIn));

  // R4: a shift moves the old next-to-top bit onto the output
  a_r4_shift_step: assert property (@(posedge clk) disable iff (!clearN)
    strobes.doShift |=> (serOut == $past(stateQ[TOP-1])) && (stateQ[0] == $past(serIn)));

  // R5: no strobe means the word is held
  a_r5_hold: assert property (@(posedge clk) disable iff (!clearN)
    (!strobes.doLoad && !strobes.doShift) |=> $stable(stateQ));

  // R2: while clear is held the register is empty at every edge
  a_r2_clear_empty: assert property (@(posedge clk)
    !clearN |-> (stateQ == '0));
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             clkEnN,
  input  logic             loadN,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut
);
  stepStrobes_t strobes;

  piso_ctrl uCtrl (
    .clkEnN (clkEnN),
    .loadN  (loadN),
    .strobes(strobes)
  );

  piso_datapath #(.WIDTH(WIDTH)) uPath (
    .clk    (clk),
    .clearN (clearN),
    .strobes(strobes),
    .serIn  (serIn),
    .parIn  (parIn),
    .serOut (serOut)
  );
endmodule

// File: tb/tb_piso_shifter.sv
module tb_piso_shifter;
  localparam int WIDTH = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic clearN = 1'b0, clkEnN = 1'b1, loadN = 1'b1, serIn = 1'b0;
  logic [WIDTH-1:0] parHead = '0, parTail = '0;
  logic outHead, outTail;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [WIDTH-1:0] mHead = '0, mTail = '0;
  bit    qHead[$];
  bit    qTail[$];
  string qReq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_shifter #(.WIDTH(WIDTH)) dut (
    .clk(clk), .clearN(clearN), .clkEnN(clkEnN), .loadN(loadN),
    .serIn(serIn), .parIn(parHead), .serOut(outHead));

  piso_shifter #(.WIDTH(WIDTH)) dutTail (
    .clk(clk), .clearN(clearN), .clkEnN(clkEnN), .loadN(loadN),
    .serIn(outHead), .parIn(parTail), .serOut(outTail));

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: set inputs at the falling edge, update the model, queue the outcome.
  task automatic step(input logic en, input logic ld, input logic [WIDTH-1:0] dH,
                      input logic [WIDTH-1:0] dT, input logic sIn, input string req);
    logic [WIDTH-1:0] nH, nT;
    @(negedge clk);
    clkEnN = en; loadN = ld; parHead = dH; parTail = dT; serIn = sIn;
    nH = mHead; nT = mTail;
    if (!clearN) begin nH = '0; nT = '0; end
    else if (!en) begin
      if (!ld) begin nH = dH; nT = dT; end
      else begin
        nT = {mTail[WIDTH-2:0], mHead[WIDTH-1]};
        nH = {mHead[WIDTH-2:0], sIn};
      end
    end
    mHead = nH; mTail = nT;
    qHead.push_back(mHead[WIDTH-1]);
    qTail.push_back(mTail[WIDTH-1]);
    qReq.push_back(req);
  endtask

  // Monitor: compare shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qHead.size() > 0) begin
        string r;
        bit eH, eT;
        r = qReq.pop_front();
        eH = qHead.pop_front();
        eT = qTail.pop_front();
        check(r, outHead, eH, "first stage out");
        check(r, outTail, eT, "second stage out");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2*WIDTH-1:0] word;
    // R1: reset state
    #3;
    check("R1", outHead, 1'b0, "reset head");
    check("R1", outTail, 1'b0, "reset tail");
    @(negedge clk); clearN = 1'b1;

    // R3: load two words
    step(1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0, "R3");
    // R4/R6: shift out with alternating serial input
    for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 8'h00, 8'h00, k[0], "R6");
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, "R4");
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b0, "R4");

    // R5: enable high while load and data move
    step(1'b0, 1'b0, 8'h81, 8'h7E, 1'b0, "R3");
    for (int k = 0; k < 3; k++) step(1'b1, k[0], 8'h00, 8'hFF, 1'b1, "R5");
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b0, "R5");

    // R8: load right after a partial shift
    step(1'b0, 1'b0, 8'hF0, 8'h0F, 1'b0, "R3");
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, "R4");
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, "R4");
    step(1'b0, 1'b0, 8'h2B, 8'h94, 1'b0, "R8");
    for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 8'h00, 8'h00, 1'b0, "R8");

    // R2: clear during a load
    step(1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0, "R3");
    @(posedge clk); #3;
    clkEnN = 1'b0; loadN = 1'b0;
    clearN = 1'b0;
    #1;
    check("R2", outHead, 1'b0, "async clear head");
    check("R2", outTail, 1'b0, "async clear tail");
    mHead = '0; mTail = '0;
    step(1'b0, 1'b0, 8'hFF, 8'hFF, 1'b1, "R2");
    @(negedge clk); clearN = 1'b1; clkEnN = 1'b1;

    // R7: two-stage cascade serialises 16 bits
    step(1'b0, 1'b0, 8'h5A, 8'hC3, 1'b0, "R7");
    word = {8'hC3, 8'h5A};
    for (int k = 1; k < 2*WIDTH; k++) begin
      step(1'b0, 1'b1, 8'h00, 8'h00, 1'b0, "R7");
      @(posedge clk); #3;
      check("R7", outTail, word[2*WIDTH-1-k], "cascade bit");
    end

    @(posedge clk); #3;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule